// File: doc/BRIEF.md
# Translation Result and Fault Reporting Unit

This unit sits between a system-register access port and an address-translation walker. Software starts a virtual-to-physical translation by writing a virtual address to a dedicated register slot. The unit latches the address, presents it to the walker through a valid/ready handshake, and waits for a completion event. That event reports one of four outcomes: success with a physical page address and attribute bits, an ordinary translation fault with a fault-status value, a synchronous external abort on a walk access, or an asynchronous external abort on a walk access.

Three registers hold the outcome. The translation-result register reports successes and ordinary faults. A fault-status register and a fault-address register are touched only by external aborts. An ordinary fault never disturbs the two status registers. A synchronous abort records its encoding and the offending virtual address at once. An asynchronous abort is parked as a pending flag and reaches the fault-status register only when the core signals that the abort is taken. Software can read all three registers. It can also rewrite the result register, for example to restore it after a context switch.

Top module: `xlat_report_unit`

## Requirements
- R1: After reset, reads of the result, fault-status and fault-address registers return 0, `walk_valid` is low, and any pending asynchronous abort is discarded.
- R2: A register write at group 7, sub 8 (any selector) while idle raises `walk_valid` on the next cycle, with `walk_va` equal to the written data and `walk_op` equal to the selector. All three hold steady until `walk_ready` is seen high.
- R3: A translate write while a translation is outstanding has no effect: a waiting request keeps its address, and no new request is raised after acceptance.
- R4: Completion kind 0 (success) sets the result register to {`cpl_pa`, `cpl_attr`, 1'b0}, so bit 0 reads 0.
- R5: Completion kind 1 (ordinary fault) sets the result register to 25 zero bits, then `cpl_fs` bits 12, 10, 3, 2, 1, 0 in that order in bits [6:1], then 1 in bit 0. Fault status and fault address are left unchanged.
- R6: Completion kind 2 (synchronous walk abort) sets the fault status to 0x00C and the fault address to the virtual address of the outstanding translation. The result register is left unchanged.
- R7: Completion kind 3 (asynchronous walk abort) changes no register. The fault status becomes 0x406 on the first `abort_taken` pulse at or after that completion, and the fault address and result are not written.
- R8: An `abort_taken` pulse with no pending asynchronous abort changes no register.
- R9: A synchronous abort completing in the same cycle that a pending asynchronous abort is taken leaves the fault address at the synchronous virtual address and the fault status at 0x406.
- R10: A read returns data with `reg_rvalid` high exactly one cycle later. The result register is at (7,4,0), fault status at (5,0,0) zero-extended, and fault address at (6,0,0). Any other slot reads 0.
- R11: A write at (7,4,0) stores all 32 bits in the result register and starts no translation. A completion in the same cycle takes precedence.
- R12: Writes to the fault-status and fault-address slots are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_grp | input | 4 | Register group |
| reg_sub | input | 4 | Register sub-index |
| reg_sel | input | 3 | Operation selector |
| reg_wdata | input | 32 | Write data / virtual address |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read |
| walk_valid | output | 1 | Translation request to walker |
| walk_ready | input | 1 | Walker accepts request |
| walk_va | output | 32 | Virtual address to translate |
| walk_op | output | 3 | Request type code |
| cpl_valid | input | 1 | Completion event |
| cpl_kind | input | 2 | 0 success, 1 fault, 2 sync abort, 3 async abort |
| cpl_pa | input | 20 | Physical page address |
| cpl_attr | input | 11 | Attribute bits for result [11:1] |
| cpl_fs | input | 13 | Fault-status value for an ordinary fault |
| abort_taken | input | 1 | Core takes a pending asynchronous abort |

## Verification
Two pairs of functions can land in the same cycle. One pair is a synchronous abort completion and an `abort_taken` pulse that commits an earlier asynchronous abort. The other is a software write to the result register and a successful completion. Each pair is provoked by driving both inputs on one clock edge after setting up the pending flag or an outstanding request. The outcome is judged by reading the registers back through the register port and comparing them with the precedence the requirements state.

// File: rtl/xru_pkg.sv
package xru_pkg;

  typedef enum logic [1:0] {
    CPL_OK        = 2'd0,
    CPL_FAULT     = 2'd1,
    CPL_SYNC_ABT  = 2'd2,
    CPL_ASYNC_ABT = 2'd3
  } cpl_kind_e;

  localparam int unsigned FS_W = 13;
  localparam int unsigned FS_CODE_W = 6;

  localparam logic [FS_W-1:0] FS_SYNC_WALK = 13'h00C;
  localparam logic [FS_W-1:0] FS_ASYNC_EXT = 13'h406;

  localparam int unsigned GRP_XLAT   = 7;
  localparam int unsigned SUB_RESULT = 4;
  localparam int unsigned SUB_XLAT   = 8;
  localparam int unsigned GRP_FSTAT  = 5;
  localparam int unsigned GRP_FADDR  = 6;

  function automatic logic [FS_CODE_W-1:0] pack_fs(input logic [FS_W-1:0] fs);
    return {fs[12], fs[10], fs[3:0]};
  endfunction

endpackage

// File: rtl/xru_rst_sync.sv
module xru_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/xru_regport.sv
module xru_regport
  import xru_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned GRP_W  = 4,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [GRP_W-1:0]  reg_grp,
  input  logic [GRP_W-1:0]  reg_sub,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] result,
  input  logic [FS_W-1:0]   fstat,
  input  logic [DATA_W-1:0] faddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              wr_result,
  output logic              xlat_go
);
  logic at_result, at_xlat, at_fstat, at_faddr, rd_req;
  logic [DATA_W-1:0] rdata_n;
  logic rvalid_n;

  always_comb begin
    at_result = (reg_grp == GRP_W'(GRP_XLAT))  && (reg_sub == GRP_W'(SUB_RESULT)) && (reg_sel == '0);
    at_xlat   = (reg_grp == GRP_W'(GRP_XLAT))  && (reg_sub == GRP_W'(SUB_XLAT));
    at_fstat  = (reg_grp == GRP_W'(GRP_FSTAT)) && (reg_sub == '0) && (reg_sel == '0);
    at_faddr  = (reg_grp == GRP_W'(GRP_FADDR)) && (reg_sub == '0) && (reg_sel == '0);
    rd_req    = reg_en && !reg_wr;
    wr_result = reg_en && reg_wr && at_result;
    xlat_go   = reg_en && reg_wr && at_xlat;
  end

  always_comb begin
    rdata_n = '0;
    if (at_result)     rdata_n = result;
    else if (at_fstat) rdata_n = DATA_W'(fstat);
    else if (at_faddr) rdata_n = faddr;
    rvalid_n = rd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rvalid_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_req) rdata <= rdata_n;
  end
endmodule

// File: rtl/xru_req_ctrl.sv
module xru_req_ctrl #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlat_go,
  input  logic [DATA_W-1:0] go_va,
  input  logic [SEL_W-1:0]  go_op,
  input  logic              walk_ready,
  input  logic              cpl_valid,
  output logic              walk_valid,
  output logic [DATA_W-1:0] walk_va,
  output logic [SEL_W-1:0]  walk_op,
  output logic              busy
);
  logic accept;
  logic busy_n, wv_n;

  always_comb begin
    accept = xlat_go && !busy;
    busy_n = busy;
    wv_n   = walk_valid;
    if (accept) begin
      busy_n = 1'b1;
      wv_n   = 1'b1;
    end else begin
      if (cpl_valid) busy_n = 1'b0;
      if (walk_valid && walk_ready) wv_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      walk_valid <= 1'b0;
    end else begin
      busy       <= busy_n;
      walk_valid <= wv_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_va <= '0;
      walk_op <= '0;
    end else if (accept) begin
      walk_va <= go_va;
      walk_op <= go_op;
    end
  end
endmodule

// File: rtl/xru_fault_regs.sv
module xru_fault_regs
  import xru_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PAGE_LSB = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpl_valid,
  input  logic [1:0]                 cpl_kind,
  input  logic [DATA_W-PAGE_LSB-1:0] cpl_pa,
  input  logic [PAGE_LSB-2:0]        cpl_attr,
  input  logic [FS_W-1:0]            cpl_fs,
  input  logic [DATA_W-1:0]          xlat_va,
  input  logic                       abort_taken,
  input  logic                       wr_result,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          result,
  output logic [FS_W-1:0]            fstat,
  output logic [DATA_W-1:0]          faddr,
  output logic                       pend
);
  localparam int unsigned RSV_W = DATA_W - FS_CODE_W - 1;

  cpl_kind_e kind;
  logic [DATA_W-1:0] result_n, faddr_n;
  logic [FS_W-1:0]   fstat_n;
  logic pend_n;
  logic result_en, fstat_en, faddr_en;
  logic unused_fs;

  assign kind      = cpl_kind_e'(cpl_kind);
  assign unused_fs = ^{cpl_fs[11], cpl_fs[9:4]};

  always_comb begin
    result_n  = result;
    fstat_n   = fstat;
    faddr_n   = faddr;
    pend_n    = pend;
    result_en = 1'b0;
    fstat_en  = 1'b0;
    faddr_en  = 1'b0;
    if (wr_result) begin
      result_n  = wdata;
      result_en = 1'b1;
    end
    if (cpl_valid) begin
      unique case (kind)
        CPL_OK: begin
          result_n  = {cpl_pa, cpl_attr, 1'b0};
          result_en = 1'b1;
        end
        CPL_FAULT: begin
          result_n  = {{RSV_W{1'b0}}, pack_fs(cpl_fs), 1'b1};
          result_en = 1'b1;
        end
        CPL_SYNC_ABT: begin
          fstat_n  = FS_SYNC_WALK;
          faddr_n  = xlat_va;
          fstat_en = 1'b1;
          faddr_en = 1'b1;
        end
        CPL_ASYNC_ABT: pend_n = 1'b1;
        default: ;
      endcase
    end
    if (abort_taken && pend_n) begin
      fstat_n  = FS_ASYNC_EXT;
      fstat_en = 1'b1;
      pend_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result <= '0;
    else if (result_en) result <= result_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fstat <= '0;
    else if (fstat_en) fstat <= fstat_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        faddr <= '0;
    else if (faddr_en) faddr <= faddr_n;
  end
endmodule

// File: rtl/xlat_report_unit.sv
module xlat_report_unit
  import xru_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned PAGE_LSB    = 12,
  parameter int unsigned GRP_W       = 4,
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_en,
  input  logic                       reg_wr,
  input  logic [GRP_W-1:0]           reg_grp,
  input  logic [GRP_W-1:0]           reg_sub,
  input  logic [SEL_W-1:0]           reg_sel,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic                       reg_rvalid,
  output logic                       walk_valid,
  input  logic                       walk_ready,
  output logic [DATA_W-1:0]          walk_va,
  output logic [SEL_W-1:0]           walk_op,
  input  logic                       cpl_valid,
  input  logic [1:0]                 cpl_kind,
  input  logic [DATA_W-PAGE_LSB-1:0] cpl_pa,
  input  logic [PAGE_LSB-2:0]        cpl_attr,
  input  logic [FS_W-1:0]            cpl_fs,
  input  logic                       abort_taken
);
  logic              rst_sync_n;
  logic              wr_result, xlat_go, busy, pend_q;
  logic [DATA_W-1:0] result_q, faddr_q;
  logic [FS_W-1:0]   fstat_q;

  xru_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  xru_regport #(.DATA_W(DATA_W), .GRP_W(GRP_W), .SEL_W(SEL_W)) u_port (
    .clk(clk), .rst_n(rst_sync_n),
    .reg_en(reg_en), .reg_wr(reg_wr), .reg_grp(reg_grp), .reg_sub(reg_sub),
    .reg_sel(reg_sel), .result(result_q), .fstat(fstat_q), .faddr(faddr_q),
    .rdata(reg_rdata), .rvalid(reg_rvalid), .wr_result(wr_result), .xlat_go(xlat_go)
  );

  xru_req_ctrl #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_req (
    .clk(clk), .rst_n(rst_sync_n),
    .xlat_go(xlat_go), .go_va(reg_wdata), .go_op(reg_sel),
    .walk_ready(walk_ready), .cpl_valid(cpl_valid),
    .walk_valid(walk_valid), .walk_va(walk_va), .walk_op(walk_op), .busy(busy)
  );

  xru_fault_regs #(.DATA_W(DATA_W), .PAGE_LSB(PAGE_LSB)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .cpl_valid(cpl_valid), .cpl_kind(cpl_kind), .cpl_pa(cpl_pa),
    .cpl_attr(cpl_attr), .cpl_fs(cpl_fs), .xlat_va(walk_va),
    .abort_taken(abort_taken), .wr_result(wr_result), .wdata(reg_wdata),
    .result(result_q), .fstat(fstat_q), .faddr(faddr_q), .pend(pend_q)
  );
endmodule

// File: rtl/xru_checker.sv
module xru_checker
  import xru_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 3
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              reg_en,
  input logic              reg_wr,
  input logic              reg_rvalid,
  input logic              walk_valid,
  input logic              walk_ready,
  input logic [DATA_W-1:0] walk_va,
  input logic [SEL_W-1:0]  walk_op,
  input logic              cpl_valid,
  input logic [1:0]        cpl_kind,
  input logic              abort_taken,
  input logic              wr_result,
  input logic              pend_q,
  input logic [DATA_W-1:0] result_q,
  input logic [FS_W-1:0]   fstat_q,
  input logic [DATA_W-1:0] faddr_q
);
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_en && !reg_wr) |=> reg_rvalid); // R10
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(reg_en && !reg_wr) |=> !reg_rvalid); // R10
  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (walk_valid && !walk_ready) |=> (walk_valid && $stable(walk_va) && $stable(walk_op))); // R2
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpl_valid && cpl_kind == 2'd1 && !abort_taken) |=> ($stable(fstat_q) && $stable(faddr_q))); // R5
  AST_SYNC_ADDR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpl_valid && cpl_kind == 2'd2) |=> (faddr_q == $past(walk_va))); // R6
  AST_ABORT_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpl_valid && cpl_kind[1] && !wr_result) |=> $stable(result_q)); // R7
  AST_ASYNC_COMMIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (abort_taken && (pend_q || (cpl_valid && cpl_kind == 2'd3))) |=> (fstat_q == FS_ASYNC_EXT)); // R7
  AST_STRAY_TAKEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (abort_taken && !pend_q && !(cpl_valid && cpl_kind[1])) |=> $stable(fstat_q)); // R8
endmodule

bind xlat_report_unit xru_checker #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_xru_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .reg_en(reg_en), .reg_wr(reg_wr),
  .reg_rvalid(reg_rvalid), .walk_valid(walk_valid), .walk_ready(walk_ready),
  .walk_va(walk_va), .walk_op(walk_op), .cpl_valid(cpl_valid), .cpl_kind(cpl_kind),
  .abort_taken(abort_taken), .wr_result(wr_result), .pend_q(pend_q),
  .result_q(result_q), .fstat_q(fstat_q), .faddr_q(faddr_q)
);

// File: tb/xlat_report_unit_bench.sv
`timescale 1ns/1ps
module xlat_report_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_en, reg_wr;
  logic [3:0]  reg_grp, reg_sub;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_rvalid;
  logic        walk_valid, walk_ready;
  logic [31:0] walk_va;
  logic [2:0]  walk_op;
  logic        cpl_valid;
  logic [1:0]  cpl_kind;
  logic [19:0] cpl_pa;
  logic [10:0] cpl_attr;
  logic [12:0] cpl_fs;
  logic        abort_taken;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  xlat_report_unit u_xlat_report_unit (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_grp(reg_grp), .reg_sub(reg_sub), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .walk_valid(walk_valid), .walk_ready(walk_ready), .walk_va(walk_va),
    .walk_op(walk_op), .cpl_valid(cpl_valid), .cpl_kind(cpl_kind),
    .cpl_pa(cpl_pa), .cpl_attr(cpl_attr), .cpl_fs(cpl_fs),
    .abort_taken(abort_taken)
  );

  // vector: {kind[1:0], va[31:0], payload[31:0], op[2:0]}
  localparam int NV = 6;
  localparam logic [68:0] VEC [NV] = '{
    {2'd0, 32'h1000_0ABC, 32'hCAFE_5FFF, 3'd0},
    {2'd1, 32'h2000_0000, 32'h0000_1405, 3'd1},
    {2'd2, 32'h3456_7890, 32'h0000_0000, 3'd2},
    {2'd1, 32'h4000_0000, 32'h0000_0BFA, 3'd3},
    {2'd0, 32'hFFFF_F000, 32'h0000_0000, 3'd7},
    {2'd3, 32'h5555_0000, 32'h0000_0000, 3'd5}
  };

  logic [31:0] m_result, m_fstat, m_faddr;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] g, input logic [3:0] s, input logic [2:0] sl, input logic [31:0] d);
    reg_en = 1; reg_wr = 1; reg_grp = g; reg_sub = s; reg_sel = sl; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_wr = 0;
  endtask

  task automatic reg_read(input logic [3:0] g, input logic [3:0] s, input logic [2:0] sl, output logic [31:0] d);
    reg_en = 1; reg_wr = 0; reg_grp = g; reg_sub = s; reg_sel = sl;
    @(negedge clk);
    reg_en = 0;
    check("R10 rvalid", {31'b0, reg_rvalid}, 32'd1);
    d = reg_rdata;
  endtask

  task automatic accept_walk();
    walk_ready = 1;
    @(negedge clk);
    walk_ready = 0;
  endtask

  task automatic complete(input logic [1:0] k, input logic [31:0] p);
    cpl_valid = 1; cpl_kind = k; cpl_pa = p[31:12]; cpl_attr = p[11:1]; cpl_fs = p[12:0];
    @(negedge clk);
    cpl_valid = 0;
  endtask

  task automatic check_regs(input string req);
    logic [31:0] d;
    reg_read(4'd7, 4'd4, 3'd0, d); check({req, " result"}, d, m_result);
    reg_read(4'd5, 4'd0, 3'd0, d); check({req, " fstat"},  d, m_fstat);
    reg_read(4'd6, 4'd0, 3'd0, d); check({req, " faddr"},  d, m_faddr);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    reg_en = 0; reg_wr = 0; reg_grp = 0; reg_sub = 0; reg_sel = 0; reg_wdata = 0;
    walk_ready = 0; cpl_valid = 0; cpl_kind = 0; cpl_pa = 0; cpl_attr = 0; cpl_fs = 0;
    abort_taken = 0;
    rst_n = 0;
    @(negedge clk);
    do_reset();

    // R1 reset state
    m_result = 0; m_fstat = 0; m_faddr = 0;
    check("R1 walk_valid", {31'b0, walk_valid}, 32'd0);
    check_regs("R1");

    // vector table: R2, R4, R5, R6, R7
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  k;
      logic [31:0] va, pl;
      logic [2:0]  op;
      {k, va, pl, op} = VEC[i];
      reg_write(4'd7, 4'd8, op, va);
      check("R2 walk_valid", {31'b0, walk_valid}, 32'd1);
      check("R2 walk_va", walk_va, va);
      check("R2 walk_op", {29'b0, walk_op}, {29'b0, op});
      accept_walk();
      check("R2 walk_valid drop", {31'b0, walk_valid}, 32'd0);
      complete(k, pl);
      case (k)
        2'd0: m_result = {pl[31:12], pl[11:1], 1'b0};           // R4
        2'd1: m_result = {25'b0, pl[12], pl[10], pl[3:0], 1'b1}; // R5
        2'd2: begin m_fstat = 32'h00C; m_faddr = va; end         // R6
        default: ;                                                // R7 pending only
      endcase
      check_regs(k == 2'd0 ? "R4" : k == 2'd1 ? "R5" : k == 2'd2 ? "R6" : "R7");
    end

    // R7 commit of the pending async abort
    abort_taken = 1; @(negedge clk); abort_taken = 0;
    m_fstat = 32'h406;
    check_regs("R7 taken");

    // R8 stray abort_taken
    reg_write(4'd7, 4'd8, 3'd0, 32'h6000_1000); accept_walk();
    complete(2'd2, 32'h0);
    m_fstat = 32'h00C; m_faddr = 32'h6000_1000;
    abort_taken = 1; @(negedge clk); abort_taken = 0;
    check_regs("R8");

    // R9 sync completion and abort taken in one cycle
    reg_write(4'd7, 4'd8, 3'd0, 32'h7000_0000); accept_walk();
    complete(2'd3, 32'h0);
    reg_write(4'd7, 4'd8, 3'd0, 32'h7777_7000); accept_walk();
    cpl_valid = 1; cpl_kind = 2'd2; abort_taken = 1;
    @(negedge clk);
    cpl_valid = 0; abort_taken = 0;
    m_fstat = 32'h406; m_faddr = 32'h7777_7000;
    check_regs("R9");

    // R3 translate while outstanding
    reg_write(4'd7, 4'd8, 3'd1, 32'hAAAA_A000);
    reg_write(4'd7, 4'd8, 3'd2, 32'hBBBB_B000);
    check("R3 walk_va held", walk_va, 32'hAAAA_A000);
    check("R3 walk_op held", {29'b0, walk_op}, 32'd1);
    accept_walk();
    reg_write(4'd7, 4'd8, 3'd3, 32'hCCCC_C000);
    check("R3 no new walk", {31'b0, walk_valid}, 32'd0);
    complete(2'd0, 32'h1234_5000);
    m_result = 32'h1234_5000;
    check_regs("R3");

    // R11 restore write and no walk
    reg_write(4'd7, 4'd4, 3'd0, 32'hDEAD_BEEF);
    check("R11 no walk", {31'b0, walk_valid}, 32'd0);
    m_result = 32'hDEAD_BEEF;
    check_regs("R11");

    // R11 completion beats a same-cycle write
    reg_write(4'd7, 4'd8, 3'd0, 32'h8000_0000); accept_walk();
    reg_en = 1; reg_wr = 1; reg_grp = 4'd7; reg_sub = 4'd4; reg_sel = 3'd0; reg_wdata = 32'h1111_1111;
    cpl_valid = 1; cpl_kind = 2'd0; cpl_pa = 20'hABCDE; cpl_attr = 11'h000;
    @(negedge clk);
    reg_en = 0; reg_wr = 0; cpl_valid = 0;
    m_result = 32'hABCD_E000;
    check_regs("R11 collide");

    // R12 status slots read-only
    reg_write(4'd5, 4'd0, 3'd0, 32'hFFFF_FFFF);
    reg_write(4'd6, 4'd0, 3'd0, 32'h0BAD_F00D);
    check_regs("R12");

    // R10 unmapped slot and rvalid drop
    reg_read(4'd7, 4'd4, 3'd1, d);
    check("R10 unmapped", d, 32'h0);
    @(negedge clk);
    check("R10 rvalid low", {31'b0, reg_rvalid}, 32'd0);

    // R1 reset discards a pending async abort
    reg_write(4'd7, 4'd8, 3'd0, 32'h9000_0000); accept_walk();
    complete(2'd3, 32'h0);
    do_reset();
    abort_taken = 1; @(negedge clk); abort_taken = 0;
    m_result = 0; m_fstat = 0; m_faddr = 0;
    check_regs("R1 pending");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule